// File: doc/BRIEF.md
# Streaming Register Access Port

This block lets a small sequencer reach a register bus through two operations: one that sets a target address and one that moves data. After the address is set, every data write goes to the current address and every data read returns the contents of the current address. Each transfer then moves the address on by one, so a run of consecutive registers can be written or read without setting the address again. The address is 16 bits wide and the step wraps from 0xFFFF to 0x0000.

Some registers exist twice, once per bank, and address bit 11 picks the bank: 0 for bank 0, 1 for bank 1. The port keeps a one-bit bank value. A banked address load ORs that bit into bit 11 of the loaded address. The sequencer sends commands with a valid/ready handshake. The port sends bus transfers with its own valid/ready handshake and holds the sequencer off until the bus accepts the transfer.

The controller has three states. ST_IDLE accepts a command. It moves to ST_WRITE on a data write and to ST_READ on a data read, and stays in ST_IDLE on an address load or a bank set. ST_WRITE and ST_READ hold the bus request, stay where they are while bus_ready is low, and return to ST_IDLE on the cycle the bus accepts.

Top module: `regx_port`

## Requirements
- R1: After reset, reg_addr is 0x0000, the bank bit is 0, bus_valid and rsp_valid are low, and cmd_ready is high.
- R2: Command code 0 (address load) with cmd_wdata[16] = 0 sets reg_addr to cmd_wdata[15:0] at the accepting edge. It makes no bus transfer, and cmd_ready is high again on the next cycle.
- R3: Command code 1 (data write) makes exactly one bus transfer with bus_we = 1, bus_wdata = cmd_wdata and bus_addr = the current address. reg_addr then increments by one at the edge where the bus accepts the transfer.
- R4: Command code 2 (data read) makes one bus transfer with bus_we = 0 at the current address. rsp_valid is high for exactly one cycle, the cycle after the bus accepts, with rsp_data holding the bus_rdata value sampled at that accept. reg_addr then increments by one.
- R5: Incrementing past 0xFFFF gives 0x0000.
- R6: While bus_valid is high and bus_ready is low, bus_valid, bus_we, bus_wdata and reg_addr stay unchanged, and cmd_ready stays low.
- R7: Command code 3 (bank set) stores cmd_wdata[0] as the bank bit. It does not change reg_addr and makes no bus transfer.
- R8: Command code 0 with cmd_wdata[16] = 1 sets reg_addr to cmd_wdata[15:0] with the stored bank bit ORed into bit 11. With cmd_wdata[16] = 0 the bank bit is ignored.
- R9: Commands run in order with no overlap. A read issued after a write to the same address returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Port can accept a command (ST_IDLE) |
| cmd_op | input | 2 | 0 load address, 1 write data, 2 read data, 3 set bank |
| cmd_wdata | input | 32 | Address (bits 15:0), banked flag (bit 16), write data or bank bit (bit 0) |
| reg_addr | output | 16 | Current address, driven as the bus address |
| bus_valid | output | 1 | Bus transfer requested |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Bus accepts the transfer |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| rsp_valid | output | 1 | Read result strobe |
| rsp_data | output | 32 | Read result |

## Verification
A wrong address counter shows on reg_addr, and so on the bus address, at the very next transfer. A bench memory model that stores writes at the addresses the port actually drives exposes a wrong address within one later read of that register. A controller stuck in a busy state shows at once as cmd_ready staying low. An early release of a stalled transfer shows, in the same cycle, as a bus transfer that was never accepted. A lost or extra read strobe shows one cycle after the bus accept, as an unmatched or missing rsp_valid.

// File: rtl/regx_pkg.sv
package regx_pkg;
    typedef enum logic [1:0] {
        OP_SETADDR = 2'd0,
        OP_WRITE   = 2'd1,
        OP_READ    = 2'd2,
        OP_SETBANK = 2'd3
    } regx_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } regx_state_e;
endpackage

// File: rtl/regx_addr_ctr.sv
module regx_addr_ctr #(
    parameter int ADDR_W   = 16,
    parameter int BANK_BIT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              use_bank,
    input  logic              bank_load,
    input  logic              bank_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ONE       = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] BANK_MASK = ONE << BANK_BIT;

    logic bank_q;

    // bank bit, ORed into the address only on a banked load (R7, R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
        end else if (bank_load) begin
            bank_q <= bank_val;
        end
    end

    // address counter; the step wraps modulo 2^ADDR_W (R5)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val | ((use_bank && bank_q) ? BANK_MASK : '0);
        end else if (step) begin
            addr <= addr + ONE;
        end
    end
endmodule

// File: rtl/regx_ctrl.sv
module regx_ctrl
    import regx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic bus_ready,
    output logic cmd_ready,
    output logic bus_valid,
    output logic bus_we,
    output logic addr_load,
    output logic bank_load,
    output logic data_latch,
    output logic step,
    output logic rsp_cap
);
    regx_state_e state, state_nx;
    regx_op_e    op;

    assign op = regx_op_e'(cmd_op);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx   = state;
        cmd_ready  = 1'b0;
        bus_valid  = 1'b0;
        bus_we     = 1'b0;
        addr_load  = 1'b0;
        bank_load  = 1'b0;
        data_latch = 1'b0;
        step       = 1'b0;
        rsp_cap    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    unique case (op)
                        OP_SETADDR: addr_load = 1'b1;
                        OP_SETBANK: bank_load = 1'b1;
                        OP_WRITE: begin
                            data_latch = 1'b1;
                            state_nx   = ST_WRITE;
                        end
                        OP_READ: state_nx = ST_READ;
                        default: state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_WRITE: begin
                bus_valid = 1'b1;
                bus_we    = 1'b1;
                if (bus_ready) begin
                    step     = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            ST_READ: begin
                bus_valid = 1'b1;
                if (bus_ready) begin
                    step     = 1'b1;
                    rsp_cap  = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/regx_port.sv
module regx_port #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int BANK_BIT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int FLAG_BIT = ADDR_W;

    logic addr_load, bank_load, data_latch, step, rsp_cap;

    regx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .bus_ready  (bus_ready),
        .cmd_ready  (cmd_ready),
        .bus_valid  (bus_valid),
        .bus_we     (bus_we),
        .addr_load  (addr_load),
        .bank_load  (bank_load),
        .data_latch (data_latch),
        .step       (step),
        .rsp_cap    (rsp_cap)
    );

    regx_addr_ctr #(.ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_load),
        .load_val  (cmd_wdata[ADDR_W-1:0]),
        .use_bank  (cmd_wdata[FLAG_BIT]),
        .bank_load (bank_load),
        .bank_val  (cmd_wdata[0]),
        .step      (step),
        .addr      (reg_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_wdata <= '0;
        end else if (data_latch) begin
            bus_wdata <= cmd_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rsp_cap;
            if (rsp_cap) begin
                rsp_data <= bus_rdata;
            end
        end
    end
endmodule

// File: rtl/regx_port_sva.sv
module regx_port_sva #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_op,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd0 && !cmd_wdata[ADDR_W])
        |=> (reg_addr == $past(cmd_wdata[ADDR_W-1:0])) && cmd_ready);

    assert_write_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_we) |=> reg_addr == ($past(reg_addr) + ONE));

    assert_read_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && !bus_we)
        |=> rsp_valid && rsp_data == $past(bus_rdata) && reg_addr == ($past(reg_addr) + ONE));

    assert_rsp_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_valid && bus_ready && !bus_we));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready)
        |=> bus_valid && $stable(bus_we) && $stable(bus_wdata) && $stable(reg_addr) && !cmd_ready);

    assert_no_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !cmd_ready);

    assert_bank_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd3) |=> $stable(reg_addr) && !bus_valid);
endmodule

bind regx_port regx_port_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_wdata (cmd_wdata),
    .reg_addr  (reg_addr),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/regx_port_bench.sv
module regx_port_bench;
    typedef struct {
        logic        we;
        logic [15:0] a;
        logic [31:0] d;
    } bus_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_wdata = '0;
    logic [15:0] reg_addr;
    logic        bus_valid, bus_we;
    logic [31:0] bus_wdata;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    bus_item_t   bus_q[$];
    logic [31:0] rsp_q[$];
    logic [31:0] ref_mem[int];
    logic [31:0] bus_mem[int];
    logic [15:0] exp_addr = '0;
    logic        exp_bank = 1'b0;
    int          wait_cnt = 1;
    int          txn = 0;

    regx_port u_regx_port (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .reg_addr(reg_addr),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] dflt(input logic [15:0] a);
        return 32'hD0E00000 | {16'h0, a};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus responder: stalls by a varying count, then accepts and compares
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready = 1'b0;
            wait_cnt  = 1;
        end else if (bus_ready) begin
            bus_ready = 1'b0;
        end else if (bus_valid) begin
            if (wait_cnt > 0) begin
                // R6: held request, port busy
                check(!cmd_ready, "R6 cmd_ready", {31'b0, cmd_ready}, 32'h0);
                if (bus_q.size() > 0)
                    check(reg_addr == bus_q[0].a, "R6 addr", {16'h0, reg_addr}, {16'h0, bus_q[0].a});
                wait_cnt--;
            end else begin
                if (bus_q.size() == 0) begin
                    check(1'b0, "R9 unexpected bus transfer", {16'h0, reg_addr}, 32'h0);
                end else begin
                    bus_item_t it;
                    it = bus_q.pop_front();
                    check(bus_we == it.we, "R3/R4 bus_we", {31'b0, bus_we}, {31'b0, it.we});
                    check(reg_addr == it.a, "R3/R4 bus addr", {16'h0, reg_addr}, {16'h0, it.a});
                    if (it.we)
                        check(bus_wdata == it.d, "R3 bus_wdata", bus_wdata, it.d);
                end
                if (bus_we) bus_mem[int'(reg_addr)] = bus_wdata;
                bus_rdata = bus_mem.exists(int'(reg_addr)) ? bus_mem[int'(reg_addr)] : dflt(reg_addr);
                bus_ready = 1'b1;
                txn++;
                wait_cnt = (txn * 3) % 5;
            end
        end
    end

    // response monitor (scoreboard pop)
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (rsp_q.size() == 0) begin
                check(1'b0, "R4 extra rsp_valid", rsp_data, 32'h0);
            end else begin
                logic [31:0] e;
                e = rsp_q.pop_front();
                check(rsp_data == e, "R4/R9 rsp_data", rsp_data, e);
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [31:0] d, input string req);
        unique case (op)
            2'd0: exp_addr = d[15:0] | ((d[16] && exp_bank) ? 16'h0800 : 16'h0000);
            2'd1: begin
                bus_q.push_back('{1'b1, exp_addr, d});
                ref_mem[int'(exp_addr)] = d;
                exp_addr = exp_addr + 16'd1;
            end
            2'd2: begin
                bus_q.push_back('{1'b0, exp_addr, 32'h0});
                rsp_q.push_back(ref_mem.exists(int'(exp_addr)) ? ref_mem[int'(exp_addr)] : dflt(exp_addr));
                exp_addr = exp_addr + 16'd1;
            end
            default: exp_bank = d[0];
        endcase
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_wdata = d;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        check(reg_addr == exp_addr, req, {16'h0, reg_addr}, {16'h0, exp_addr});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(reg_addr == 16'h0, "R1 reg_addr", {16'h0, reg_addr}, 32'h0);
        check(!bus_valid && !rsp_valid, "R1 valids", {30'b0, bus_valid, rsp_valid}, 32'h0);
        check(cmd_ready, "R1 cmd_ready", {31'b0, cmd_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: bank bit resets to 0, so a banked load adds nothing
        issue(2'd0, 32'h0001_0123, "R1 bank reset");
        // R2, R3: streaming writes
        issue(2'd0, 32'h0000_0010, "R2 load");
        issue(2'd1, 32'h1111_1111, "R3 step");
        issue(2'd1, 32'h2222_2222, "R3 step");
        issue(2'd1, 32'h3333_3333, "R3 step");
        // R4, R9: streaming reads of the written registers
        issue(2'd0, 32'h0000_0010, "R2 load");
        issue(2'd2, 32'h0, "R4 step");
        issue(2'd2, 32'h0, "R4 step");
        issue(2'd2, 32'h0, "R4 step");
        issue(2'd2, 32'h0, "R4 step unwritten");
        // R5: wrap
        issue(2'd0, 32'h0000_FFFE, "R2 load");
        issue(2'd1, 32'hAAAA_0001, "R3 step");
        issue(2'd1, 32'hAAAA_0002, "R5 wrap");
        issue(2'd0, 32'h0000_FFFF, "R2 load");
        issue(2'd2, 32'h0, "R5 read wrap");
        issue(2'd2, 32'h0, "R5 read at zero");
        // R7, R8: banks
        issue(2'd3, 32'h0000_0001, "R7 addr unchanged");
        issue(2'd0, 32'h0001_0123, "R8 banked load");
        issue(2'd1, 32'hBBBB_0923, "R3 step");
        issue(2'd0, 32'h0000_0123, "R8 unbanked ignores bank");
        issue(2'd2, 32'h0, "R8 bank0 copy untouched");
        issue(2'd0, 32'h0001_0123, "R8 banked load");
        issue(2'd2, 32'h0, "R8 bank1 readback");
        issue(2'd3, 32'h0000_0000, "R7 addr unchanged");
        issue(2'd0, 32'h0001_0923, "R8 bank0 keeps bit11");
        // R9: write then read same address
        issue(2'd0, 32'h0000_0040, "R2 load");
        issue(2'd1, 32'hC0FF_EE00, "R3 step");
        issue(2'd0, 32'h0000_0040, "R2 load");
        issue(2'd2, 32'h0, "R9 read after write");
        issue(2'd1, 32'h5555_5555, "R3 step");
        issue(2'd0, 32'h0000_0041, "R2 load");
        issue(2'd2, 32'h0, "R9 read after write");
        repeat (4) @(negedge clk);
        check(bus_q.size() == 0, "R3/R4 pending bus items", bus_q.size(), 32'h0);
        check(rsp_q.size() == 0, "R4 missing responses", rsp_q.size(), 32'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule